// File: doc/BRIEF.md
# Block-Streamed Entering Column Selector

This block is the pricing stage of a tile-streamed simplex engine. A tableau enters as a sequence of tiles, one tile per clock. Each tile is `TILE_H` rows by `TILE_W` columns. The tiles arrive row-major, starting at the top-left tile. A start strobe announces each problem and gives its size in tiles: `cols_i` tiles across and `rows_i` tiles down, both at least one.

The first tile-row carries the reduced-cost row. Each tile's share of that row goes through a comparator tree, and the tile's winner is merged into a running best that is kept across the tile-row. When the tile-row ends, the block reports the global index of the most negative reduced cost, or it reports that the problem is optimal. For every later tile-row, the block slices out the chosen column and the right-hand-side column, and it hands both downstream as vectors, one vector pair per tile-row. The block also marks the first tile of each tile-row and the first tile of each problem.

Top module: `entering_col_selector`

## Requirements
- R1: After reset, every output is zero until the first tile is accepted.
- R2: A tile is accepted only if `tile_valid_i` is high, a problem is open and `start_i` is low. A problem opens at a start strobe and closes after its last tile. Any other tile has no effect on any output. Tile element (row a, lane b) sits at bit offset (a*TILE_W+b)*DATA_W of `tile_i`.
- R3: One cycle after a tile is accepted, `sync_row_o` is high if that tile is in tile-column 0. In the same cycle, `sync_prob_o` is high if that tile is the top-left tile.
- R4: Pricing uses only element row 0 of the first tile-row, read as signed two's complement. It picks the most negative value that is strictly below zero. The reported index is tile_column*TILE_W+lane. The last tableau column (lane TILE_W-1 of the last tile in a row) holds the right-hand side and is never a candidate.
- R5: When two candidates are equal, the lower column index wins. This holds for a tie inside one tile and for a tie between tiles.
- R6: If no candidate is below zero, `dec_opt_o` is 1 and no vectors are emitted for that problem.
- R7: `dec_valid_o` pulses for one cycle, exactly one cycle after the last tile of the first tile-row is accepted. `dec_opt_o` and `dec_col_o` are valid with it and hold until the next decision.
- R8: For a problem that is not optimal, each tile-row from 1 onward produces one `vec_valid_o` pulse. The pulse comes one cycle after the last tile of that tile-row is accepted. `col_vec_o` holds the entering column's elements for that tile-row, element a at offset a*DATA_W. `rhs_vec_o` holds lane TILE_W-1 of the row's last tile. `vec_row_o` gives the tile-row index.
- R9: The entering column may lie in the last tile of a tile-row. In that case both vectors are taken from that same tile in the same cycle.
- R10: Cycles with `tile_valid_i` low do not advance the tile position. A stream with gaps gives the same results as a stream without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-of-problem strobe; loads the tile counts |
| cols_i | input | CNT_W | Tiles per tile-row (1..MAX_TILES) |
| rows_i | input | CNT_W | Tile-rows per problem (1..MAX_TILES) |
| tile_valid_i | input | 1 | Tile present on `tile_i` |
| tile_i | input | TILE_H*TILE_W*DATA_W | One tile of signed elements |
| sync_row_o | output | 1 | First tile of a tile-row was accepted last cycle |
| sync_prob_o | output | 1 | First tile of a problem was accepted last cycle |
| dec_valid_o | output | 1 | Pricing decision pulse |
| dec_opt_o | output | 1 | Problem is optimal (no negative reduced cost) |
| dec_col_o | output | COL_W | Global entering column index |
| vec_valid_o | output | 1 | Column and right-hand-side vectors valid |
| vec_row_o | output | IDX_W | Tile-row index of the vectors |
| col_vec_o | output | TILE_H*DATA_W | Entering-column elements of the tile-row |
| rhs_vec_o | output | TILE_H*DATA_W | Right-hand-side elements of the tile-row |

## Verification
The column slice and the right-hand-side slice can be taken from the same tile in the same cycle. This happens when the winning column sits in the last tile of a tile-row, so that one tile both finishes the row and supplies the entering column. The bench provokes this case by placing the minimum in a lane of the last tile, with idle gaps between the tiles. The scoreboard then requires each vector pair to match the tableau rows it came from, and checks the pulse one cycle after the closing tile. A second case is a row with a single tile, where pricing and the exclusion of the right-hand-side lane apply to the same tile.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRICE,
    PH_GATHER
  } phase_e;

  function automatic int width_of(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ecs_tile_tracker.sv
module ecs_tile_tracker
  import ecs_pkg::*;
#(
  parameter int MAX_TILES = 8,
  parameter int CNT_W     = 4,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cols_i,
  input  logic [CNT_W-1:0] rows_i,
  input  logic             valid_i,
  output logic             acc_o,
  output logic             pricing_o,
  output logic [IDX_W-1:0] tcol_o,
  output logic [IDX_W-1:0] trow_o,
  output logic             row_last_o
);
  phase_e           ph;
  logic [CNT_W-1:0] cols_r, rows_r;
  logic [IDX_W-1:0] tcol, trow;
  logic             prob_last;

  assign acc_o      = (ph != PH_IDLE) && valid_i && !start_i;
  assign pricing_o  = (ph == PH_PRICE);
  assign tcol_o     = tcol;
  assign trow_o     = trow;
  assign row_last_o = (CNT_W'(tcol) == cols_r - CNT_W'(1));
  assign prob_last  = row_last_o && (CNT_W'(trow) == rows_r - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cols_r <= '0;
      rows_r <= '0;
      tcol   <= '0;
      trow   <= '0;
    end else if (start_i) begin
      ph     <= PH_PRICE;
      cols_r <= cols_i;
      rows_r <= rows_i;
      tcol   <= '0;
      trow   <= '0;
    end else if (acc_o) begin
      if (row_last_o) begin
        tcol <= '0;
        if (prob_last) begin
          ph <= PH_IDLE;
        end else begin
          trow <= trow + IDX_W'(1);
          ph   <= PH_GATHER;
        end
      end else begin
        tcol <= tcol + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/ecs_min_tree.sv
module ecs_min_tree #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int LANE_W = 2
) (
  input  logic [LANES*DATA_W-1:0] vals_i,
  input  logic [LANES-1:0]        mask_i,
  output logic signed [DATA_W-1:0] val_o,
  output logic [LANE_W-1:0]        lane_o,
  output logic                     vld_o
);
  localparam int LEAVES = 1 << $clog2(LANES);
  localparam int NODES  = 2 * LEAVES - 1;

  logic signed [DATA_W-1:0] nv [NODES];
  logic [LANE_W-1:0]        ni [NODES];
  logic                     nk [NODES];

  always_comb begin
    for (int j = 0; j < LEAVES; j++) begin
      if (j < LANES) begin
        nv[LEAVES-1+j] = vals_i[j*DATA_W +: DATA_W];
        ni[LEAVES-1+j] = LANE_W'(j);
        nk[LEAVES-1+j] = mask_i[j];
      end else begin
        nv[LEAVES-1+j] = '0;
        ni[LEAVES-1+j] = '0;
        nk[LEAVES-1+j] = 1'b0;
      end
    end
    for (int i = LEAVES - 2; i >= 0; i--) begin
      // left child holds the lower lanes and wins on equality
      if (nk[2*i+2] && (!nk[2*i+1] || (nv[2*i+2] < nv[2*i+1]))) begin
        nv[i] = nv[2*i+2];
        ni[i] = ni[2*i+2];
      end else begin
        nv[i] = nv[2*i+1];
        ni[i] = ni[2*i+1];
      end
      nk[i] = nk[2*i+1] | nk[2*i+2];
    end
  end

  assign val_o  = nv[0];
  assign lane_o = ni[0];
  assign vld_o  = nk[0];
endmodule

// File: rtl/ecs_col_slicer.sv
module ecs_col_slicer #(
  parameter int TILE_W = 4,
  parameter int TILE_H = 4,
  parameter int DATA_W = 16,
  parameter int LANE_W = 2,
  parameter int IDX_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       take_i,
  input  logic                       row_last_i,
  input  logic                       hit_i,
  input  logic [LANE_W-1:0]          lane_i,
  input  logic [IDX_W-1:0]           trow_i,
  input  logic [TILE_H*TILE_W*DATA_W-1:0] tile_i,
  output logic                       vec_valid_o,
  output logic [IDX_W-1:0]           vec_row_o,
  output logic [TILE_H*DATA_W-1:0]   col_vec_o,
  output logic [TILE_H*DATA_W-1:0]   rhs_vec_o
);
  localparam int VEC_W = TILE_H * DATA_W;

  logic [VEC_W-1:0] cur_col, cur_rhs, col_lat;

  always_comb begin
    for (int a = 0; a < TILE_H; a++) begin
      cur_col[a*DATA_W +: DATA_W] = tile_i[(a*TILE_W + int'(lane_i))*DATA_W +: DATA_W];
      cur_rhs[a*DATA_W +: DATA_W] = tile_i[(a*TILE_W + TILE_W - 1)*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid_o <= 1'b0;
      vec_row_o   <= '0;
      col_vec_o   <= '0;
      rhs_vec_o   <= '0;
      col_lat     <= '0;
    end else begin
      vec_valid_o <= 1'b0;
      if (take_i && hit_i) col_lat <= cur_col;
      if (take_i && row_last_i) begin
        vec_valid_o <= 1'b1;
        vec_row_o   <= trow_i;
        col_vec_o   <= hit_i ? cur_col : col_lat;
        rhs_vec_o   <= cur_rhs;
      end
    end
  end
endmodule

// File: rtl/entering_col_selector.sv
module entering_col_selector
  import ecs_pkg::*;
#(
  parameter int TILE_W    = 4,
  parameter int TILE_H    = 4,
  parameter int DATA_W    = 16,
  parameter int MAX_TILES = 8,
  localparam int CNT_W    = $clog2(MAX_TILES + 1),
  localparam int IDX_W    = width_of(MAX_TILES),
  localparam int LANE_W   = width_of(TILE_W),
  localparam int COL_W    = width_of(MAX_TILES * TILE_W)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start_i,
  input  logic [CNT_W-1:0]                cols_i,
  input  logic [CNT_W-1:0]                rows_i,
  input  logic                            tile_valid_i,
  input  logic [TILE_H*TILE_W*DATA_W-1:0] tile_i,
  output logic                            sync_row_o,
  output logic                            sync_prob_o,
  output logic                            dec_valid_o,
  output logic                            dec_opt_o,
  output logic [COL_W-1:0]                dec_col_o,
  output logic                            vec_valid_o,
  output logic [IDX_W-1:0]                vec_row_o,
  output logic [TILE_H*DATA_W-1:0]        col_vec_o,
  output logic [TILE_H*DATA_W-1:0]        rhs_vec_o
);
  logic             acc, pricing, row_last;
  logic [IDX_W-1:0] tcol, trow;

  ecs_tile_tracker #(.MAX_TILES(MAX_TILES), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_track (
    .clk(clk), .rst(rst), .start_i(start_i), .cols_i(cols_i), .rows_i(rows_i),
    .valid_i(tile_valid_i), .acc_o(acc), .pricing_o(pricing),
    .tcol_o(tcol), .trow_o(trow), .row_last_o(row_last)
  );

  // candidate mask: the right-hand-side lane of the closing tile never competes
  logic [TILE_W-1:0] lane_mask;
  always_comb begin
    for (int j = 0; j < TILE_W; j++) lane_mask[j] = !(row_last && (j == TILE_W - 1));
  end

  logic signed [DATA_W-1:0] win_val;
  logic [LANE_W-1:0]        win_lane;
  logic                     win_vld;

  ecs_min_tree #(.LANES(TILE_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) i_tree (
    .vals_i(tile_i[TILE_W*DATA_W-1:0]), .mask_i(lane_mask),
    .val_o(win_val), .lane_o(win_lane), .vld_o(win_vld)
  );

  logic signed [DATA_W-1:0] best_val;
  logic [IDX_W-1:0]         best_tile, tile_n;
  logic [LANE_W-1:0]        best_lane, lane_n;
  logic                     found, found_n, take;

  assign take    = acc && pricing && win_vld && (win_val < 0) && (!found || (win_val < best_val));
  assign found_n = found | take;
  assign tile_n  = take ? tcol : best_tile;
  assign lane_n  = take ? win_lane : best_lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      best_val    <= '0;
      best_tile   <= '0;
      best_lane   <= '0;
      found       <= 1'b0;
      dec_valid_o <= 1'b0;
      dec_opt_o   <= 1'b0;
      dec_col_o   <= '0;
      sync_row_o  <= 1'b0;
      sync_prob_o <= 1'b0;
    end else begin
      sync_row_o  <= acc && (tcol == '0);
      sync_prob_o <= acc && (tcol == '0) && (trow == '0);
      dec_valid_o <= 1'b0;
      if (start_i) begin
        found <= 1'b0;
      end else begin
        if (take) begin
          best_val  <= win_val;
          best_tile <= tcol;
          best_lane <= win_lane;
          found     <= 1'b1;
        end
        if (acc && pricing && row_last) begin
          dec_valid_o <= 1'b1;
          dec_opt_o   <= !found_n;
          dec_col_o   <= COL_W'(tile_n) * COL_W'(TILE_W) + COL_W'(lane_n);
        end
      end
    end
  end

  ecs_col_slicer #(
    .TILE_W(TILE_W), .TILE_H(TILE_H), .DATA_W(DATA_W), .LANE_W(LANE_W), .IDX_W(IDX_W)
  ) i_slice (
    .clk(clk), .rst(rst),
    .take_i(acc && !pricing && found), .row_last_i(row_last),
    .hit_i(tcol == best_tile), .lane_i(best_lane), .trow_i(trow),
    .tile_i(tile_i), .vec_valid_o(vec_valid_o), .vec_row_o(vec_row_o),
    .col_vec_o(col_vec_o), .rhs_vec_o(rhs_vec_o)
  );
endmodule

// File: rtl/ecs_sel_checker.sv
module ecs_sel_checker (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic sync_row_o,
  input logic sync_prob_o,
  input logic dec_valid_o,
  input logic dec_opt_o,
  input logic vec_valid_o,
  input logic vec_row_any
);
  assert_prob_in_row_R3: assert property (@(posedge clk) disable iff (rst)
    sync_prob_o |-> sync_row_o);

  assert_start_takes_no_tile_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !sync_row_o);

  assert_dec_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    dec_valid_o |=> !dec_valid_o);

  assert_dec_apart_from_vec_R7: assert property (@(posedge clk) disable iff (rst)
    dec_valid_o |-> !vec_valid_o);

  assert_optimal_no_vec_R6: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> !dec_opt_o);

  assert_vec_row_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> vec_row_any);
endmodule

bind entering_col_selector ecs_sel_checker i_ecs_chk (
  .clk(clk), .rst(rst), .start_i(start_i),
  .sync_row_o(sync_row_o), .sync_prob_o(sync_prob_o),
  .dec_valid_o(dec_valid_o), .dec_opt_o(dec_opt_o),
  .vec_valid_o(vec_valid_o), .vec_row_any(|vec_row_o)
);

// File: tb/test_entering_col_selector.sv
`timescale 1ns/1ps
module test_entering_col_selector;
  localparam int W = 4, H = 4, DW = 16, MT = 8;
  localparam int CNT_W = 4, IDX_W = 3, COL_W = 5;
  localparam int VW = H * DW;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, tile_valid_i = 1'b0;
  logic [CNT_W-1:0] cols_i = '0, rows_i = '0;
  logic [H*W*DW-1:0] tile_i = '0;
  logic sync_row_o, sync_prob_o, dec_valid_o, dec_opt_o, vec_valid_o;
  logic [COL_W-1:0] dec_col_o;
  logic [IDX_W-1:0] vec_row_o;
  logic [VW-1:0] col_vec_o, rhs_vec_o;

  always #2.5 clk = ~clk;

  entering_col_selector #(.TILE_W(W), .TILE_H(H), .DATA_W(DW), .MAX_TILES(MT)) i_entering_col_selector (
    .clk(clk), .rst(rst), .start_i(start_i), .cols_i(cols_i), .rows_i(rows_i),
    .tile_valid_i(tile_valid_i), .tile_i(tile_i),
    .sync_row_o(sync_row_o), .sync_prob_o(sync_prob_o),
    .dec_valid_o(dec_valid_o), .dec_opt_o(dec_opt_o), .dec_col_o(dec_col_o),
    .vec_valid_o(vec_valid_o), .vec_row_o(vec_row_o),
    .col_vec_o(col_vec_o), .rhs_vec_o(rhs_vec_o)
  );

  typedef struct {
    bit is_vec;
    bit opt;
    int col;
    int row;
    logic [VW-1:0] cv;
    logic [VW-1:0] rv;
  } item_t;

  item_t exp_q[$];
  int tab[32][32];
  int errors = 0, checks = 0;
  int seed = 12345;
  bit mon_en = 1'b0;
  bit exp_row = 0, exp_prob = 0, exp_dec = 0, exp_vec = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int rnd(input int lo, input int hi);
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return lo + (seed % (hi - lo + 1));
  endfunction

  // monitor: compares outputs one step after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_en) begin
        chk(sync_row_o == exp_row, "R3", "sync_row", VW'(sync_row_o), VW'(exp_row));
        chk(sync_prob_o == exp_prob, "R3", "sync_prob", VW'(sync_prob_o), VW'(exp_prob));
        chk(dec_valid_o == exp_dec, "R7", "dec_valid timing", VW'(dec_valid_o), VW'(exp_dec));
        chk(vec_valid_o == exp_vec, "R8", "vec_valid timing", VW'(vec_valid_o), VW'(exp_vec));
        if (dec_valid_o) begin
          if (exp_q.size() == 0 || exp_q[0].is_vec) begin
            chk(0, "R7", "unexpected decision", VW'(dec_col_o), '0);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            chk(dec_opt_o == it.opt, "R6", "optimal flag", VW'(dec_opt_o), VW'(it.opt));
            if (!it.opt)
              chk(int'(dec_col_o) == it.col, "R4/R5", "entering column", VW'(dec_col_o), VW'(it.col));
          end
        end
        if (vec_valid_o) begin
          if (exp_q.size() == 0 || !exp_q[0].is_vec) begin
            chk(0, "R8", "unexpected vectors", col_vec_o, '0);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            chk(int'(vec_row_o) == it.row, "R8", "vector row", VW'(vec_row_o), VW'(it.row));
            chk(col_vec_o == it.cv, "R8", "column vector", col_vec_o, it.cv);
            chk(rhs_vec_o == it.rv, "R9", "rhs vector", rhs_vec_o, it.rv);
          end
        end
      end
    end
  end

  task automatic fill(input int p, input int q);
    for (int r = 0; r < q * H; r++)
      for (int c = 0; c < p * W; c++)
        tab[r][c] = (r == 0) ? rnd(0, 90) : rnd(-200, 200);
  endtask

  task automatic idle_drive();
    tile_valid_i = 1'b0;
    exp_row = 0; exp_prob = 0; exp_dec = 0; exp_vec = 0;
  endtask

  task automatic run(input int p, input int q, input bit gaps, input bit tile_at_start);
    int best = 0;
    bit found = 0;
    item_t it;
    for (int c = 0; c < p * W - 1; c++)
      if (tab[0][c] < 0 && (!found || tab[0][c] < best)) begin
        best = tab[0][c]; found = 1; it.col = c;
      end
    it.is_vec = 0; it.opt = !found; it.row = 0; it.cv = '0; it.rv = '0;
    exp_q.push_back(it);
    if (found)
      for (int t = 1; t < q; t++) begin
        item_t v;
        v.is_vec = 1; v.opt = 0; v.col = it.col; v.row = t;
        for (int a = 0; a < H; a++) begin
          v.cv[a*DW +: DW] = DW'(tab[t*H+a][it.col]);
          v.rv[a*DW +: DW] = DW'(tab[t*H+a][p*W-1]);
        end
        exp_q.push_back(v);
      end
    @(negedge clk);
    idle_drive();
    start_i = 1'b1; cols_i = CNT_W'(p); rows_i = CNT_W'(q);
    tile_valid_i = tile_at_start;  // R2: a tile presented with the strobe is dropped
    @(negedge clk);
    start_i = 1'b0;
    for (int tr = 0; tr < q; tr++)
      for (int tc = 0; tc < p; tc++) begin
        for (int a = 0; a < H; a++)
          for (int b = 0; b < W; b++)
            tile_i[(a*W+b)*DW +: DW] = DW'(tab[tr*H+a][tc*W+b]);
        tile_valid_i = 1'b1;
        exp_row = (tc == 0); exp_prob = (tc == 0 && tr == 0);
        exp_dec = (tr == 0 && tc == p - 1);
        exp_vec = found && tr > 0 && tc == p - 1;
        @(negedge clk);
        if (gaps && (tc % 2 == 0)) begin  // R10: idle cycle between tiles
          idle_drive();
          tile_i = '1;
          @(negedge clk);
        end
      end
    idle_drive();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "pending results", VW'(exp_q.size()), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: outputs after reset
    chk({sync_row_o, sync_prob_o, dec_valid_o, dec_opt_o, vec_valid_o} == '0, "R1", "flags", '0, '0);
    chk(dec_col_o == '0 && vec_row_o == '0, "R1", "indices", VW'(dec_col_o), '0);
    chk(col_vec_o == '0 && rhs_vec_o == '0, "R1", "vectors", col_vec_o, '0);
    mon_en = 1'b1;

    // R2: tiles with no open problem are ignored
    tile_i = '1; tile_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    idle_drive();
    @(negedge clk);

    // R4: general case
    fill(3, 3); tab[0][5] = -120; tab[0][2] = -60; tab[0][9] = -119;
    run(3, 3, 0, 0);

    // R5: ties inside a tile (5,6) and across tiles (9)
    fill(3, 2); tab[0][5] = -7; tab[0][6] = -7; tab[0][9] = -7; tab[0][2] = -3;
    run(3, 2, 0, 0);

    // R6: only the objective entry is negative, zeros are not candidates
    fill(2, 3); tab[0][0] = 0; tab[0][3] = 0; tab[0][7] = -500;
    run(2, 3, 0, 0);

    // R9 + R10 + R2: winner in the closing tile, gapped stream, tile on strobe
    fill(3, 4); tab[0][10] = -77; tab[0][1] = -76;
    run(3, 4, 1, 1);

    // R4: one tile per row, most negative code value, RHS lane excluded
    fill(1, 2); tab[0][0] = -32768; tab[0][1] = -5; tab[0][3] = -32768;
    run(1, 2, 0, 0);

    // R4 + R9: widest row, winner just left of the RHS lane
    fill(8, 2); tab[0][30] = -300; tab[0][31] = -999; tab[0][12] = -299;
    run(8, 2, 1, 0);

    mon_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule